// File: doc/BRIEF.md
# Task-Tagged Translation Cache

This block keeps recently used logical-to-physical page mappings in a fully associative store of 64 slots. Each lookup presents a logical page number, a bus function code, a 3-bit task alias and a read/write flag. The block compares all three key fields against every valid slot at once. One clock later it reports either a hit, with the stored physical page, write-protect bit and cache-inhibit bit, or a miss. On a hit the physical strobe is raised unless the access is a write to a write-protected page. In that case a write violation is flagged and the strobe stays low.

A separate table-walk unit reacts to misses and installs the missing mapping through the fill port, one slot per cycle. A fill whose key is already present rewrites that slot. Otherwise the fill takes a free slot, and when no slot is free it takes the unlocked slot with the oldest history. The task alias extends the key, so up to eight tasks can keep mappings in the store together. A flush command drops every unlocked mapping that belongs to one alias and leaves the other aliases alone.

Top module: `xlat_cache`

## Requirements
- R1: After reset no slot is valid, every lookup misses, and `rsp_valid` is low until a lookup is made.
- R2: A lookup hits only when the page number, the function code and the task alias all equal those of one valid slot. A difference in any one of the three gives a miss.
- R3: A lookup presented in cycle n is answered in cycle n+1. In that cycle `rsp_valid` is high and, on a hit, `rsp_ppn`, `rsp_wp` and `rsp_ci` carry the values the slot was filled with. With no lookup, `rsp_valid` is low.
- R4: A miss raises `rsp_miss` with `rsp_hit`, `rsp_strobe` and `rsp_wviol` all low.
- R5: A write lookup that hits a slot with the write-protect bit set gives `rsp_wviol`=1 and `rsp_strobe`=0. A read lookup of the same slot gives `rsp_strobe`=1 and `rsp_wviol`=0.
- R6: A fill accepted in cycle n is visible to a lookup made in cycle n+1.
- R7: A fill whose key matches a valid slot rewrites that slot in place, so one key never occupies two slots and a later lookup returns the newest physical page.
- R8: A flush with a given alias invalidates every unlocked slot carrying that alias. Slots with other aliases still hit.
- R9: A locked slot survives flushes of its own alias and is never chosen as a replacement victim.
- R10: While any slot is free, a fill goes to a free slot, so 64 distinct fills after reset all remain resident.
- R11: When every slot is valid, a fill evicts the unlocked slot whose history age is greatest. The age of a slot is cleared when it is filled or hit, and it grows by one, saturating, on every hit or fill of another slot. Ties go to the lowest slot index.
- R12: When every slot is valid and locked, and the fill key is not already present, the fill is discarded and the resident mappings are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_lpn | input | LPN_W | Logical page number to translate |
| lk_fc | input | FC_W | Bus function code of the access |
| lk_alias | input | ALIAS_W | Task alias of the access |
| lk_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Lookup answer is present |
| rsp_hit | output | 1 | Lookup matched a slot |
| rsp_miss | output | 1 | Lookup matched no slot; table walk needed |
| rsp_ppn | output | PPN_W | Physical page of the matching slot, zero otherwise |
| rsp_wp | output | 1 | Write-protect bit of the matching slot |
| rsp_ci | output | 1 | Cache-inhibit bit of the matching slot |
| rsp_wviol | output | 1 | Write to a write-protected page |
| rsp_strobe | output | 1 | Physical strobe: hit without violation |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_lpn | input | LPN_W | Page number of the new mapping |
| fill_fc | input | FC_W | Function code of the new mapping |
| fill_alias | input | ALIAS_W | Task alias of the new mapping |
| fill_ppn | input | PPN_W | Physical page of the new mapping |
| fill_wp | input | 1 | Write-protect bit of the new mapping |
| fill_ci | input | 1 | Cache-inhibit bit of the new mapping |
| fill_lock | input | 1 | Lock the new mapping against eviction and flush |
| flush_valid | input | 1 | Flush one alias this cycle |
| flush_alias | input | ALIAS_W | Alias whose unlocked slots are dropped |

## Verification
Four checks run on every cycle: the one-cycle answer timing, the rule that a violation is only ever raised by a write, the absence of strobe and hit on a miss, and the rule that no key matches two slots at once. A further per-slot check holds a locked slot valid across flushes. Which slot a fill evicts, how lookups reorder the history, the survival of other aliases across a flush, and the dropping of fills when every slot is locked depend on long histories of fills and lookups. Only the directed scenarios of the bench show those behaviours, through later hits and misses.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 64,
  parameter int LPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int FC_W    = 3,
  parameter int ALIAS_W = 3,
  parameter int AGE_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [LPN_W-1:0]   lk_lpn,
  input  logic [FC_W-1:0]    lk_fc,
  input  logic [ALIAS_W-1:0] lk_alias,
  input  logic               lk_write,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic [PPN_W-1:0]   rsp_ppn,
  output logic               rsp_wp,
  output logic               rsp_ci,
  output logic               rsp_wviol,
  output logic               rsp_strobe,
  input  logic               fill_valid,
  input  logic [LPN_W-1:0]   fill_lpn,
  input  logic [FC_W-1:0]    fill_fc,
  input  logic [ALIAS_W-1:0] fill_alias,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic               fill_wp,
  input  logic               fill_ci,
  input  logic               fill_lock,
  input  logic               flush_valid,
  input  logic [ALIAS_W-1:0] flush_alias
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] lock_q;
  logic [AGE_W-1:0]   age_q   [ENTRIES];
  logic [LPN_W-1:0]   lpn_q   [ENTRIES];
  logic [FC_W-1:0]    fc_q    [ENTRIES];
  logic [ALIAS_W-1:0] alias_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q   [ENTRIES];
  logic [ENTRIES-1:0] wp_q;
  logic [ENTRIES-1:0] ci_q;

  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] fmatch_vec;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid_q[g] && lpn_q[g] == lk_lpn &&
                          fc_q[g] == lk_fc && alias_q[g] == lk_alias;
      assign fmatch_vec[g] = valid_q[g] && lpn_q[g] == fill_lpn &&
                             fc_q[g] == fill_fc && alias_q[g] == fill_alias;
    end
  endgenerate

  wire hit_any  = |hit_vec;
  wire fmatch   = |fmatch_vec;

  logic [IDX_W-1:0] hit_idx, fmatch_idx;
  always_comb begin
    hit_idx    = '0;
    fmatch_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i])    hit_idx    = IDX_W'(i);
      if (fmatch_vec[i]) fmatch_idx = IDX_W'(i);
    end
  end

  logic             inv_found, old_found, wr_ok;
  logic [IDX_W-1:0] inv_idx, old_idx, wr_idx;
  logic [AGE_W-1:0] old_age;
  always_comb begin
    inv_found = 1'b0;
    inv_idx   = '0;
    old_found = 1'b0;
    old_idx   = '0;
    old_age   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_q[i] && !inv_found) begin
        inv_found = 1'b1;
        inv_idx   = IDX_W'(i);
      end
      if (valid_q[i] && !lock_q[i] && (!old_found || age_q[i] > old_age)) begin
        old_found = 1'b1;
        old_idx   = IDX_W'(i);
        old_age   = age_q[i];
      end
    end
    if (fmatch) begin
      wr_ok = 1'b1; wr_idx = fmatch_idx;
    end else if (inv_found) begin
      wr_ok = 1'b1; wr_idx = inv_idx;
    end else begin
      wr_ok = old_found; wr_idx = old_idx;
    end
  end

  wire do_fill = fill_valid && wr_ok;
  wire do_hit  = lk_valid && hit_any;
  wire touch   = do_hit || do_fill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      lock_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_valid && valid_q[i] && !lock_q[i] && alias_q[i] == flush_alias)
          valid_q[i] <= 1'b0;
        if (touch && valid_q[i] && age_q[i] != AGE_MAX)
          age_q[i] <= age_q[i] + 1'b1;
        if (do_hit && hit_vec[i])
          age_q[i] <= '0;
      end
      if (do_fill) begin
        valid_q[wr_idx] <= 1'b1;
        lock_q[wr_idx]  <= fill_lock;
        age_q[wr_idx]   <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      lpn_q[wr_idx]   <= fill_lpn;
      fc_q[wr_idx]    <= fill_fc;
      alias_q[wr_idx] <= fill_alias;
      ppn_q[wr_idx]   <= fill_ppn;
      wp_q[wr_idx]    <= fill_wp;
      ci_q[wr_idx]    <= fill_ci;
    end
  end

  wire hit_wp = wp_q[hit_idx];
  wire viol   = do_hit && lk_write && hit_wp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_ppn    <= '0;
      rsp_wp     <= 1'b0;
      rsp_ci     <= 1'b0;
      rsp_wviol  <= 1'b0;
      rsp_strobe <= 1'b0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= do_hit;
      rsp_miss   <= lk_valid && !hit_any;
      rsp_ppn    <= do_hit ? ppn_q[hit_idx] : '0;
      rsp_wp     <= do_hit && hit_wp;
      rsp_ci     <= do_hit && ci_q[hit_idx];
      rsp_wviol  <= viol;
      rsp_strobe <= do_hit && !viol;
    end
  end

  // R3
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  // R5
  wviol_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wviol |-> $past(lk_write));

  // R4
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (!rsp_strobe && !rsp_hit && !rsp_wviol));

  // R7
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  generate
    for (g = 0; g < ENTRIES; g++) begin : g_lock_chk
      // R9
      lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q[g] && lock_q[g]) |=> valid_q[g]);
    end
  endgenerate

endmodule

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0;
  logic [19:0] lk_lpn = '0;
  logic [2:0]  lk_fc = '0, lk_alias = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_wp, rsp_ci, rsp_wviol, rsp_strobe;
  logic [19:0] rsp_ppn;
  logic        fill_valid = 1'b0, fill_wp = 1'b0, fill_ci = 1'b0, fill_lock = 1'b0;
  logic [19:0] fill_lpn = '0, fill_ppn = '0;
  logic [2:0]  fill_fc = '0, fill_alias = '0;
  logic        flush_valid = 1'b0;
  logic [2:0]  flush_alias = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_lpn(lk_lpn), .lk_fc(lk_fc), .lk_alias(lk_alias),
    .lk_write(lk_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_ppn(rsp_ppn),
    .rsp_wp(rsp_wp), .rsp_ci(rsp_ci), .rsp_wviol(rsp_wviol), .rsp_strobe(rsp_strobe),
    .fill_valid(fill_valid), .fill_lpn(fill_lpn), .fill_fc(fill_fc),
    .fill_alias(fill_alias), .fill_ppn(fill_ppn), .fill_wp(fill_wp),
    .fill_ci(fill_ci), .fill_lock(fill_lock),
    .flush_valid(flush_valid), .flush_alias(flush_alias)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_fill(input logic [19:0] lpn, input logic [2:0] fc, input logic [2:0] al,
                         input logic [19:0] ppn, input logic wp, input logic ci,
                         input logic lk);
    fill_valid = 1'b1; fill_lpn = lpn; fill_fc = fc; fill_alias = al;
    fill_ppn = ppn; fill_wp = wp; fill_ci = ci; fill_lock = lk;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_lookup(input logic [19:0] lpn, input logic [2:0] fc,
                           input logic [2:0] al, input logic wr);
    lk_valid = 1'b1; lk_lpn = lpn; lk_fc = fc; lk_alias = al; lk_write = wr;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [19:0] lpn, input logic [2:0] al,
                            input logic exp_hit);
    do_lookup(lpn, 3'd1, al, 1'b0);
    check(req, {31'd0, rsp_hit}, {31'd0, exp_hit});
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
    do_lookup(20'h00042, 3'd1, 3'd0, 1'b0);
    check("R1 miss after reset", {31'd0, rsp_miss}, 32'd1);
    check("R4 no strobe on miss", {31'd0, rsp_strobe}, 32'd0);
    check("R4 no hit on miss", {31'd0, rsp_hit}, 32'd0);
  endtask

  task automatic t_basic();
    do_reset();
    do_fill(20'h12345, 3'd5, 3'd1, 20'hABCDE, 1'b0, 1'b1, 1'b0);
    do_lookup(20'h12345, 3'd5, 3'd1, 1'b0);
    check("R6 hit right after fill", {31'd0, rsp_hit}, 32'd1);
    check("R3 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check("R3 ppn", {12'd0, rsp_ppn}, 32'h000ABCDE);
    check("R3 ci", {31'd0, rsp_ci}, 32'd1);
    check("R3 wp", {31'd0, rsp_wp}, 32'd0);
    check("R5 strobe on clean hit", {31'd0, rsp_strobe}, 32'd1);
    @(negedge clk);
    check("R3 rsp_valid drops", {31'd0, rsp_valid}, 32'd0);
    do_lookup(20'h12345, 3'd6, 3'd1, 1'b0);
    check("R2 fc mismatch misses", {31'd0, rsp_miss}, 32'd1);
    do_lookup(20'h12345, 3'd5, 3'd2, 1'b0);
    check("R2 alias mismatch misses", {31'd0, rsp_miss}, 32'd1);
    do_lookup(20'h12346, 3'd5, 3'd1, 1'b0);
    check("R2 page mismatch misses", {31'd0, rsp_miss}, 32'd1);
    check("R4 ppn zero on miss", {12'd0, rsp_ppn}, 32'd0);
  endtask

  task automatic t_protect();
    do_reset();
    do_fill(20'h00777, 3'd1, 3'd3, 20'h00888, 1'b1, 1'b0, 1'b0);
    do_lookup(20'h00777, 3'd1, 3'd3, 1'b1);
    check("R5 write violation", {31'd0, rsp_wviol}, 32'd1);
    check("R5 no strobe on violation", {31'd0, rsp_strobe}, 32'd0);
    check("R5 still a hit", {31'd0, rsp_hit}, 32'd1);
    do_lookup(20'h00777, 3'd1, 3'd3, 1'b0);
    check("R5 read no violation", {31'd0, rsp_wviol}, 32'd0);
    check("R5 read strobe", {31'd0, rsp_strobe}, 32'd1);
  endtask

  task automatic t_refill();
    do_reset();
    do_fill(20'h00100, 3'd1, 3'd0, 20'h00011, 1'b0, 1'b0, 1'b0);
    do_fill(20'h00100, 3'd1, 3'd0, 20'h00022, 1'b0, 1'b0, 1'b0);
    do_lookup(20'h00100, 3'd1, 3'd0, 1'b0);
    check("R7 newest ppn", {12'd0, rsp_ppn}, 32'h00000022);
  endtask

  task automatic t_flush();
    do_reset();
    do_fill(20'h00010, 3'd1, 3'd2, 20'h1, 1'b0, 1'b0, 1'b0);
    do_fill(20'h00011, 3'd1, 3'd2, 20'h2, 1'b0, 1'b0, 1'b1);
    do_fill(20'h00012, 3'd1, 3'd5, 20'h3, 1'b0, 1'b0, 1'b0);
    flush_valid = 1'b1; flush_alias = 3'd2;
    @(negedge clk);
    flush_valid = 1'b0;
    expect_hit("R8 flushed alias misses", 20'h00010, 3'd2, 1'b0);
    expect_hit("R9 locked survives flush", 20'h00011, 3'd2, 1'b1);
    expect_hit("R8 other alias kept", 20'h00012, 3'd5, 1'b1);
  endtask

  task automatic t_fill_all();
    do_reset();
    for (int k = 0; k < N; k++) do_fill(20'h01000 + 20'(k), 3'd1, 3'd0, 20'(k), 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < N; k++) expect_hit("R10 all resident", 20'h01000 + 20'(k), 3'd0, 1'b1);
  endtask

  task automatic t_lru();
    do_reset();
    for (int k = 0; k < N; k++) do_fill(20'h02000 + 20'(k), 3'd1, 3'd0, 20'(k), 1'b0, 1'b0, 1'b0);
    do_fill(20'h02000 + 20'(N), 3'd1, 3'd0, 20'h0, 1'b0, 1'b0, 1'b0);
    expect_hit("R11 oldest evicted", 20'h02000, 3'd0, 1'b0);
    expect_hit("R11 new entry present", 20'h02000 + 20'(N), 3'd0, 1'b1);
    expect_hit("R11 second oldest kept", 20'h02001, 3'd0, 1'b1);
    do_fill(20'h02000 + 20'(N + 1), 3'd1, 3'd0, 20'h0, 1'b0, 1'b0, 1'b0);
    expect_hit("R11 touched entry kept", 20'h02001, 3'd0, 1'b1);
    expect_hit("R11 next oldest evicted", 20'h02002, 3'd0, 1'b0);
  endtask

  task automatic t_lock();
    do_reset();
    for (int k = 0; k < N; k++)
      do_fill(20'h03000 + 20'(k), 3'd1, 3'd0, 20'(k), 1'b0, 1'b0, k == 0);
    do_fill(20'h03000 + 20'(N), 3'd1, 3'd0, 20'h0, 1'b0, 1'b0, 1'b0);
    expect_hit("R9 locked oldest kept", 20'h03000, 3'd0, 1'b1);
    expect_hit("R9 oldest unlocked evicted", 20'h03001, 3'd0, 1'b0);
    expect_hit("R11 new entry present", 20'h03000 + 20'(N), 3'd0, 1'b1);
  endtask

  task automatic t_all_locked();
    do_reset();
    for (int k = 0; k < N; k++) do_fill(20'h04000 + 20'(k), 3'd1, 3'd4, 20'(k), 1'b0, 1'b0, 1'b1);
    do_fill(20'h04000 + 20'(N), 3'd1, 3'd4, 20'h0, 1'b0, 1'b0, 1'b0);
    expect_hit("R12 fill dropped", 20'h04000 + 20'(N), 3'd4, 1'b0);
    expect_hit("R12 first kept", 20'h04000, 3'd4, 1'b1);
    expect_hit("R12 last kept", 20'h04000 + 20'(N - 1), 3'd4, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_protect();
    t_refill();
    t_flush();
    t_fill_all();
    t_lru();
    t_lock();
    t_all_locked();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule